// File: doc/BRIEF.md
# Infrared Receive Symbol FIFO with Interrupt Status

This block sits between an infrared sampler and a host. The sampler sends 8-bit run-length symbols, and the block queues them in a FIFO. The FIFO holds a power-of-two number of entries, normally 16 or 64. The host reads from a data port that shows the oldest symbol, and each read strobe pops that symbol. The symbol input is a valid/ready stream. `sym_ready` is held high: the block never stalls the sampler. A symbol offered while the FIFO is full and no pop happens in the same cycle is discarded, and the overflow flag records the loss.

A status word packs three sticky flags with the live entry count: overflow, packet end and data available. The data-available flag is raised whenever the entry count after a clock edge exceeds a trigger level. The host programs that level in the interrupt-control word, next to one enable bit per flag. Each flag is cleared by writing a one to its bit position in the status word. The interrupt line is high while any flag is set together with its enable.

Top module: `ir_rx_fifo_status`

## Requirements
- R1: After reset the FIFO is empty, the status word is zero, all enables and the trigger level are zero, `irq` is low and `rd_data` is zero.
- R2: Symbols leave in arrival order. `rd_data[7:0]` shows the oldest stored symbol, `rd_data[31:8]` is always zero, and a `rd_pop` pulse removes that symbol at the clock edge.
- R3: Status bits from 8 upward, `$clog2(DEPTH+1)` bits wide, hold the current entry count. This field reads DEPTH when the FIFO is full.
- R4: A symbol offered while the FIFO is full, with no pop in the same cycle, is dropped. The stored contents and count are unchanged, and status bit 0 (overflow) becomes 1.
- R5: A symbol offered while full, in the same cycle as a pop, is accepted. The count stays at DEPTH and no overflow is flagged.
- R6: A one-cycle `pkt_end` pulse sets status bit 1 (packet end).
- R7: Status bit 4 (data available) becomes 1 at any edge after which the entry count is greater than the trigger level. The trigger level is held in interrupt-control bits from 8 upward, with the same width as the count field.
- R8: A status write clears each flag whose bit is 1 in `sta_wdata[7:0]` and leaves the others alone. A set condition in the same cycle wins over the clear.
- R9: `irq` is high exactly when some flag is set and its enable is 1. Interrupt-control bit 0 enables overflow, bit 1 enables packet end and bit 4 enables data available.
- R10: A pop while the FIFO is empty is ignored. The count stays zero and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | Sampler offers a symbol |
| sym_ready | output | 1 | Always 1; overflow drops instead of stalling |
| sym_data | input | 8 | Run-length symbol |
| pkt_end | input | 1 | Packet-end strobe from the sampler |
| rd_pop | input | 1 | Host read strobe, pops the oldest symbol |
| rd_data | output | 32 | Oldest symbol in bits 7:0, zero elsewhere |
| sta_wr | input | 1 | Status write strobe (write-one-to-clear) |
| sta_wdata | input | 32 | Status write data; low byte is the clear mask |
| ien_wr | input | 1 | Interrupt-control write strobe |
| ien_wdata | input | 32 | Enables at bits 0, 1, 4; trigger level from bit 8 |
| status | output | 32 | Flags at bits 0, 1, 4; entry count from bit 8 |
| irq | output | 1 | OR of enabled, set flags |

## Verification
The bench fills the FIFO to the last entry and then offers one more symbol. A design with an off-by-one full test would either store the extra symbol, reading back the wrong head, or report a count that wraps to zero. It then pushes and pops together while full: a design that checks fullness before crediting the pop would drop the symbol and raise a false overflow. The data-available flag is tested at the step from level to level+1 and cleared while still above the level. A design that compared with greater-or-equal would fire one symbol early, and one that let the clear win would lose the event. Pops on an empty FIFO catch counters that underflow to a huge count.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int unsigned NFLAG    = 3;
  localparam int unsigned BIT_OVF  = 0;
  localparam int unsigned BIT_PEND = 1;
  localparam int unsigned BIT_AVL  = 4;
  localparam int unsigned FIELD_LSB = 8;

  typedef enum logic [1:0] {FK_OVF = 2'd0, FK_PEND = 2'd1, FK_AVL = 2'd2} flag_kind_e;

  function automatic int unsigned flag_pos(int unsigned k);
    case (k)
      0:       return BIT_OVF;
      1:       return BIT_PEND;
      default: return BIT_AVL;
    endcase
  endfunction
endpackage

// File: rtl/ir_sym_fifo.sv
module ir_sym_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SYM_W = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [SYM_W-1:0] push_data,
  input  logic             pop_req,
  output logic [SYM_W-1:0] head_data,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_nxt,
  output logic             drop
);
  logic [SYM_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic full, empty, pop_ok, push_ok;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign empty   = (count_q == '0);
  assign pop_ok  = pop_req && !empty;
  assign push_ok = push_req && (!full || pop_ok);
  assign drop    = push_req && !push_ok;

  always_comb begin
    count_nxt = count_q;
    if (push_ok && !pop_ok) count_nxt = count_q + CNT_W'(1);
    else if (pop_ok && !push_ok) count_nxt = count_q - CNT_W'(1);
  end

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count_q <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  assign head_data = empty ? '0 : mem[rd_ptr];

  // R3: count never exceeds the depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  // R4: a dropped symbol leaves the count unchanged
  a_r4_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(count_q));
  // R10: pop on empty with no push keeps the count at zero
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req) |=> (count_q == '0));
endmodule

// File: rtl/ir_irq_flags.sv
module ir_irq_flags
  import ir_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_evt,
  input  logic             pend_evt,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] level,
  input  logic             clr_wr,
  input  logic [7:0]       clr_mask,
  input  logic [NFLAG-1:0] enable,
  output logic [NFLAG-1:0] flag_q,
  output logic             irq
);
  logic [NFLAG-1:0] set_evt;
  assign set_evt[FK_OVF]  = ovf_evt;
  assign set_evt[FK_PEND] = pend_evt;
  assign set_evt[FK_AVL]  = (cnt_nxt > level);

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    localparam int unsigned POS = flag_pos(k);
    logic clr_k;
    assign clr_k = clr_wr && clr_mask[POS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[k] <= 1'b0;
      else        flag_q[k] <= set_evt[k] || (flag_q[k] && !clr_k);
    end

    // R8: a flag stays set unless its bit is written with one
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[k] && !clr_k) |=> flag_q[k]);
  end

  assign irq = |(flag_q & enable);

  // R4: an overflow event always leaves the overflow flag set
  a_r4_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_q[FK_OVF]);
  // R6: a packet-end strobe always leaves the packet-end flag set
  a_r6_pend_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pend_evt |=> flag_q[FK_PEND]);
endmodule

// File: rtl/ir_rx_fifo_status.sv
module ir_rx_fifo_status
  import ir_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SYM_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sym_valid,
  output logic        sym_ready,
  input  logic [7:0]  sym_data,
  input  logic        pkt_end,
  input  logic        rd_pop,
  output logic [31:0] rd_data,
  input  logic        sta_wr,
  input  logic [31:0] sta_wdata,
  input  logic        ien_wr,
  input  logic [31:0] ien_wdata,
  output logic [31:0] status,
  output logic        irq
);
  logic [SYM_W-1:0] head;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, level_q;
  logic             drop;
  logic [NFLAG-1:0] en_q, flags;

  assign sym_ready = 1'b1;

  ir_sym_fifo #(.DEPTH(DEPTH), .SYM_W(SYM_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(sym_valid), .push_data(sym_data),
    .pop_req(rd_pop), .head_data(head),
    .count_q(cnt_q), .count_nxt(cnt_nxt), .drop(drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      level_q <= '0;
    end else if (ien_wr) begin
      for (int k = 0; k < NFLAG; k++) en_q[k] <= ien_wdata[flag_pos(k)];
      level_q <= ien_wdata[FIELD_LSB +: CNT_W];
    end
  end

  ir_irq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ovf_evt(drop), .pend_evt(pkt_end),
    .cnt_nxt(cnt_nxt), .level(level_q),
    .clr_wr(sta_wr), .clr_mask(sta_wdata[7:0]),
    .enable(en_q), .flag_q(flags), .irq(irq)
  );

  always_comb begin
    status = '0;
    for (int k = 0; k < NFLAG; k++) status[flag_pos(k)] = flags[k];
    status[FIELD_LSB +: CNT_W] = cnt_q;
  end

  assign rd_data = {{(32-SYM_W){1'b0}}, head};

  // R9: with every enable clear the line stays low
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
  // R2: upper data bits never carry anything
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:8] == '0);
endmodule

// File: tb/ir_rx_fifo_status_bench.sv
module ir_rx_fifo_status_bench;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic sym_valid = 0, pkt_end = 0, rd_pop = 0, sta_wr = 0, ien_wr = 0;
  logic [7:0] sym_data = 0;
  logic [31:0] sta_wdata = 0, ien_wdata = 0;
  logic sym_ready, irq;
  logic [31:0] rd_data, status;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ir_rx_fifo_status #(.DEPTH(DEPTH)) u_ir_rx_fifo_status (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data), .pkt_end(pkt_end), .rd_pop(rd_pop), .rd_data(rd_data),
    .sta_wr(sta_wr), .sta_wdata(sta_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .status(status), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cnt();
    return (status >> 8) & ((32'd1 << CW) - 1);
  endfunction

  // one clock: inputs set at a falling edge, released at the next
  task automatic step(bit v, logic [7:0] d, bit p, bit pe);
    @(negedge clk);
    sym_valid = v; sym_data = d; rd_pop = p; pkt_end = pe;
    @(negedge clk);
    sym_valid = 0; rd_pop = 0; pkt_end = 0;
  endtask

  task automatic wr_sta(logic [31:0] v);
    @(negedge clk); sta_wr = 1; sta_wdata = v;
    @(negedge clk); sta_wr = 0;
  endtask

  task automatic wr_ien(logic [31:0] v);
    @(negedge clk); ien_wr = 1; ien_wdata = v;
    @(negedge clk); ien_wr = 0;
  endtask

  // {kind: 0 push / 1 pop, value, count after}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'hA1, 8'd1}, {1'b0, 8'hB2, 8'd2}, {1'b0, 8'hC3, 8'd3},
    {1'b1, 8'hA1, 8'd2}, {1'b0, 8'hD4, 8'd3}, {1'b1, 8'hB2, 8'd2},
    {1'b1, 8'hC3, 8'd1}, {1'b1, 8'hD4, 8'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 status", status, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 rd_data", rd_data, 0);
    check("R4 sym_ready", {31'd0, sym_ready}, 1);

    foreach (VEC[i]) begin
      if (VEC[i][16]) begin
        check("R2 head", rd_data, {24'd0, VEC[i][15:8]});
        step(0, 0, 1, 0);
      end else step(1, VEC[i][15:8], 0, 0);
      check("R3 count", cnt(), {24'd0, VEC[i][7:0]});
    end

    step(0, 0, 1, 0);                       // R10 pop on empty
    check("R10 count", cnt(), 0);
    check("R10 rd_data", rd_data, 0);

    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 0, 0);
    check("R3 full count", cnt(), DEPTH);
    wr_sta(32'hFF);
    step(1, 8'hEE, 0, 0);
    check("R4 ovf flag", {31'd0, status[0]}, 1);
    check("R4 count held", cnt(), DEPTH);
    check("R4 head kept", rd_data, 32'h10);
    wr_sta(32'h01);
    check("R8 ovf cleared", {31'd0, status[0]}, 0);
    step(1, 8'hF0, 1, 0);
    check("R5 count", cnt(), DEPTH);
    check("R5 no ovf", {31'd0, status[0]}, 0);
    for (int i = 0; i < DEPTH; i++) begin
      check("R5 drain order", rd_data, (i < DEPTH - 1) ? 32'h11 + i : 32'hF0);
      step(0, 0, 1, 0);
    end
    check("R2 empty", cnt(), 0);

    wr_sta(32'hFF);
    check("R8 all clear", status, 0);
    wr_ien(32'h0000_0310);                  // avail enable, level 3
    for (int i = 0; i < 3; i++) step(1, 8'(i), 0, 0);
    check("R7 at level", {31'd0, status[4]}, 0);
    check("R9 irq low", {31'd0, irq}, 0);
    step(1, 8'h33, 0, 0);
    check("R7 above level", {31'd0, status[4]}, 1);
    check("R9 irq avail", {31'd0, irq}, 1);
    wr_sta(32'h10);
    check("R8 set wins", {31'd0, status[4]}, 1);
    step(0, 0, 1, 0);
    wr_sta(32'h10);
    check("R8 avail cleared", {31'd0, status[4]}, 0);
    check("R9 irq dropped", {31'd0, irq}, 0);

    step(0, 0, 0, 1);
    check("R6 pend flag", {31'd0, status[1]}, 1);
    check("R9 pend masked", {31'd0, irq}, 0);
    wr_ien(32'h0000_0302);
    check("R9 pend irq", {31'd0, irq}, 1);
    wr_sta(32'h0);
    check("R8 zero write", {31'd0, status[1]}, 1);
    wr_sta(32'h02);
    check("R8 pend cleared", {31'd0, status[1]}, 0);
    check("R9 irq off", {31'd0, irq}, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule